// File: doc/BRIEF.md
# Transceiver Diagnostic Threshold Flags and Soft Control

This block keeps the live monitor readings of an optical transceiver, compares each reading against four programmable limits, and presents everything as a byte-addressed register space. A serial slave elsewhere on the chip reads and writes this space. The five monitored quantities are internal temperature, supply voltage, transmitter bias current, transmitted optical power and received optical power. They arrive one at a time from a conversion front end. Each arrival carries a quantity index and a 16-bit word.

When a word arrives, the block stores it as that quantity's real-time value. In the same clock edge it refreshes that quantity's two alarm flags and two warning flags from the threshold bytes held at that moment. The block also holds a status and control byte. That byte carries a software transmit-disable bit, the effective transmit-disable state, a copy of the loss-of-signal pin and an inverted data-valid indication. The effective disable also drives the `tx_off` output.

Top module: `diag_monitor_regs`

## Requirements
- R1: Temperature (index 0) is compared as a signed two's-complement word. Supply, bias, transmit power and receive power are compared as unsigned words.
- R2: Bytes 0 to 39 hold the threshold words and are writable. Each quantity has an 8-byte group at offset 8*index. Within a group the words appear in the order high alarm, low alarm, high warning, low warning, most significant byte first. All threshold bytes reset to 0.
- R3: Bytes 96 to 105 return the latest stored value of each quantity, 2 bytes per quantity in index order, most significant byte first. The values reset to 0.
- R4: A high flag is 1 only when the sample is strictly above its high limit. A low flag is 1 only when the sample is strictly below its low limit. A sample equal to a limit does not set that flag.
- R5: Byte 112 holds the alarm flags from bit 7 down to bit 0 in this order: temperature high, temperature low, supply high, supply low, bias high, bias low, transmit power high, transmit power low. Byte 113 holds receive power high in bit 7 and receive power low in bit 6. Bits 5 to 0 of byte 113 read 0.
- R6: Bytes 116 and 117 hold the warning flags, in the same bit arrangement as bytes 112 and 113.
- R7: Byte 110 reads as follows: bit 7 is the effective disable, bit 6 is the soft disable, bit 1 is the loss-of-signal pin (1 means loss) and bit 0 is data-not-ready. Bits 5 to 2 read 0. A write to byte 110 changes only bit 6.
- R8: `tx_off` is 1 whenever `txdis_pin` is 1 or the soft disable bit is 1. An open host pin is pulled high, so it reads as 1.
- R9: The data-not-ready bit is 1 after reset. It goes to 0 in the cycle after each of the five quantities has been sampled at least once, and it then stays 0 until the next reset.
- R10: Flags change only on a sample strobe for their own quantity. They are not sticky: an in-range sample clears them. A threshold write leaves the flags unchanged until the next sample of that quantity.
- R11: Writes to any address other than 0 to 39 and 110 have no effect. Reads of unmapped addresses return 0.
- R12: The sample index uses the encoding 0 temperature, 1 supply, 2 bias, 3 transmit power, 4 receive power. A strobe with an index of 5 or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_sel | input | 3 | Quantity index of the sample |
| smp_data | input | 16 | Sample word |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Read byte, combinational from rd_addr |
| txdis_pin | input | 1 | Hardware transmit-disable pin, high or open means disable |
| los_pin | input | 1 | Receiver loss-of-signal pin |
| tx_off | output | 1 | Effective transmitter disable |

## Verification
The hardest case to reach is a sample that lands exactly on a threshold, or one count either side of it, while the threshold itself is being rewritten nearby. Random stimulus almost never produces these values. The stimulus therefore builds each sample word from the current threshold of a randomly chosen quantity and limit, plus an offset of -1, 0 or +1, so that the strict-comparison boundaries are hit constantly. Directed steps cover the cases random stimulus is unlikely to produce: a negative temperature that would look large if compared unsigned, a threshold rewrite followed by the same sample again, and the exact strobe that completes the first full set of five samples.

// File: rtl/diag_pkg.sv
package diag_pkg;
   localparam int NQ      = 5;
   localparam int NLIM    = 4;
   localparam int A_RT    = 96;
   localparam int A_STAT  = 110;
   localparam int A_ALM   = 112;
   localparam int A_WRN   = 116;
   localparam int ST_TXOFF = 7;
   localparam int ST_SOFT  = 6;
   localparam int ST_LOS   = 1;
   localparam int ST_NRDY  = 0;

   typedef enum logic [1:0] {
      LIM_HA = 2'd0,
      LIM_LA = 2'd1,
      LIM_HW = 2'd2,
      LIM_LW = 2'd3
   } lim_e;

   typedef struct packed {
      logic hi;
      logic lo;
   } hl_t;
endpackage

// File: rtl/diag_chan.sv
module diag_chan #(
   parameter int DW        = 16,
   parameter bit IS_SIGNED = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld,
   input  logic [DW-1:0]   smp,
   input  logic [DW-1:0]   lim_ha,
   input  logic [DW-1:0]   lim_la,
   input  logic [DW-1:0]   lim_hw,
   input  logic [DW-1:0]   lim_lw,
   output logic [DW-1:0]   val,
   output diag_pkg::hl_t   alm,
   output diag_pkg::hl_t   wrn
);
   logic ha_x, la_x, hw_x, lw_x;

   generate
      if (IS_SIGNED) begin : g_sgn
         always_comb begin
            ha_x = $signed(smp) > $signed(lim_ha);
            la_x = $signed(smp) < $signed(lim_la);
            hw_x = $signed(smp) > $signed(lim_hw);
            lw_x = $signed(smp) < $signed(lim_lw);
         end
      end else begin : g_uns
         always_comb begin
            ha_x = smp > lim_ha;
            la_x = smp < lim_la;
            hw_x = smp > lim_hw;
            lw_x = smp < lim_lw;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val <= '0;
         alm <= '0;
         wrn <= '0;
      end else if (ld) begin
         val    <= smp;
         alm.hi <= ha_x;
         alm.lo <= la_x;
         wrn.hi <= hw_x;
         wrn.lo <= lw_x;
      end
   end
endmodule

// File: rtl/diag_rdmux.sv
module diag_rdmux #(
   parameter int DW  = 16,
   parameter int AW  = 8,
   parameter int NTB = 40
) (
   input  logic [AW-1:0]               rd_addr,
   input  logic [NTB*8-1:0]            thr_flat,
   input  logic [diag_pkg::NQ*DW-1:0]  val_flat,
   input  logic [2*diag_pkg::NQ-1:0]   alm_vec,
   input  logic [2*diag_pkg::NQ-1:0]   wrn_vec,
   input  logic [7:0]                  stat,
   output logic [7:0]                  rd_data
);
   import diag_pkg::*;
   localparam int BPV = DW / 8;
   localparam int NFB = (2*NQ + 7) / 8;

   logic [NFB*8-1:0] alm_pad, wrn_pad;

   always_comb begin
      alm_pad = '0;
      wrn_pad = '0;
      alm_pad[NFB*8-1 -: 2*NQ] = alm_vec;
      wrn_pad[NFB*8-1 -: 2*NQ] = wrn_vec;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NTB; i++)
         if (rd_addr == AW'(i)) rd_data = thr_flat[i*8 +: 8];
      for (int q = 0; q < NQ; q++)
         for (int b = 0; b < BPV; b++)
            if (rd_addr == AW'(A_RT + q*BPV + b))
               rd_data = val_flat[q*DW + (BPV-1-b)*8 +: 8];
      if (rd_addr == AW'(A_STAT)) rd_data = stat;
      for (int j = 0; j < NFB; j++) begin
         if (rd_addr == AW'(A_ALM + j)) rd_data = alm_pad[(NFB-1-j)*8 +: 8];
         if (rd_addr == AW'(A_WRN + j)) rd_data = wrn_pad[(NFB-1-j)*8 +: 8];
      end
   end
endmodule

// File: rtl/diag_monitor_regs.sv
module diag_monitor_regs #(
   parameter int          DW          = 16,
   parameter int          AW          = 8,
   parameter int          SEL_W       = 3,
   parameter logic [4:0]  SIGNED_MASK = 5'b00001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [SEL_W-1:0]  smp_sel,
   input  logic [DW-1:0]     smp_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [7:0]        rd_data,
   input  logic              txdis_pin,
   input  logic              los_pin,
   output logic              tx_off
);
   import diag_pkg::*;
   localparam int BPV = DW / 8;
   localparam int NTB = NQ * NLIM * BPV;

   generate
      if (DW % 8 != 0) begin : g_bad_dw
         $error("DW must be a whole number of bytes");
      end
      if (NTB > A_RT || A_RT + NQ*BPV > A_STAT) begin : g_bad_map
         $error("register regions overlap for this DW");
      end
      if ((1 << SEL_W) < NQ || (1 << AW) <= A_WRN + 1) begin : g_bad_w
         $error("SEL_W or AW too narrow");
      end
   endgenerate

   logic [7:0]         thr_q [NTB];
   logic [NTB*8-1:0]   thr_flat;
   logic [DW-1:0]      lim_w [NQ][NLIM];
   logic [NQ*DW-1:0]   val_flat;
   logic [2*NQ-1:0]    alm_vec, wrn_vec;
   logic [NQ-1:0]      seen;
   logic               rdy;
   logic               soft_dis;
   logic [7:0]         stat;

   // threshold byte storage, one register per address
   genvar gi;
   generate
      for (gi = 0; gi < NTB; gi++) begin : g_thr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               thr_q[gi] <= '0;
            else if (wr_en && wr_addr == AW'(gi))
               thr_q[gi] <= wr_data;
         end
         assign thr_flat[gi*8 +: 8] = thr_q[gi];
      end
   endgenerate

   // assemble limit words, most significant byte at the lower address
   always_comb begin
      for (int q = 0; q < NQ; q++)
         for (int k = 0; k < NLIM; k++)
            for (int b = 0; b < BPV; b++)
               lim_w[q][k][(BPV-1-b)*8 +: 8] = thr_q[(q*NLIM + k)*BPV + b];
   end

   generate
      for (gi = 0; gi < NQ; gi++) begin : g_ch
         logic  ld;
         hl_t   alm, wrn;
         assign ld = smp_valid && (smp_sel == SEL_W'(gi));

         diag_chan #(.DW(DW), .IS_SIGNED(SIGNED_MASK[gi])) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld),
            .smp    (smp_data),
            .lim_ha (lim_w[gi][LIM_HA]),
            .lim_la (lim_w[gi][LIM_LA]),
            .lim_hw (lim_w[gi][LIM_HW]),
            .lim_lw (lim_w[gi][LIM_LW]),
            .val    (val_flat[gi*DW +: DW]),
            .alm    (alm),
            .wrn    (wrn)
         );

         assign alm_vec[2*NQ-1-2*gi] = alm.hi;
         assign alm_vec[2*NQ-2-2*gi] = alm.lo;
         assign wrn_vec[2*NQ-1-2*gi] = wrn.hi;
         assign wrn_vec[2*NQ-2-2*gi] = wrn.lo;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  seen[gi] <= 1'b0;
            else if (ld) seen[gi] <= 1'b1;
         end
      end
   endgenerate

   assign rdy = &seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         soft_dis <= 1'b0;
      else if (wr_en && wr_addr == AW'(A_STAT))
         soft_dis <= wr_data[ST_SOFT];
   end

   assign tx_off = txdis_pin | soft_dis;

   always_comb begin
      stat           = '0;
      stat[ST_TXOFF] = tx_off;
      stat[ST_SOFT]  = soft_dis;
      stat[ST_LOS]   = los_pin;
      stat[ST_NRDY]  = ~rdy;
   end

   diag_rdmux #(.DW(DW), .AW(AW), .NTB(NTB)) u_rdmux (
      .rd_addr  (rd_addr),
      .thr_flat (thr_flat),
      .val_flat (val_flat),
      .alm_vec  (alm_vec),
      .wrn_vec  (wrn_vec),
      .stat     (stat),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/diag_monitor_regs_chk.sv
module diag_monitor_regs_chk #(
   parameter int AW  = 8,
   parameter int NF  = 10,
   parameter int NTB = 40
) (
   input logic            clk,
   input logic            rst_n,
   input logic            smp_valid,
   input logic            wr_en,
   input logic [AW-1:0]   wr_addr,
   input logic [7:0]      wr_data,
   input logic [AW-1:0]   rd_addr,
   input logic [7:0]      rd_data,
   input logic            tx_off,
   input logic [NF-1:0]   alm_vec,
   input logic [NF-1:0]   wrn_vec,
   input logic            rdy,
   input logic [NTB*8-1:0] thr_flat
);
   // R10
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ($stable(alm_vec) && $stable(wrn_vec)));

   // R9
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |=> rdy);

   // R8
   soft_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(diag_pkg::A_STAT) && wr_data[diag_pkg::ST_SOFT]) |=> tx_off);

   // R11
   thr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr < AW'(NTB)) |=> $stable(thr_flat));

   // R5
   alm_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == AW'(diag_pkg::A_ALM + 1)) |-> (rd_data[5:0] == 6'd0));

   // R6
   wrn_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == AW'(diag_pkg::A_WRN + 1)) |-> (rd_data[5:0] == 6'd0));
endmodule

bind diag_monitor_regs diag_monitor_regs_chk #(.AW(AW), .NF(2*diag_pkg::NQ), .NTB(NTB)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .rd_addr   (rd_addr),
   .rd_data   (rd_data),
   .tx_off    (tx_off),
   .alm_vec   (alm_vec),
   .wrn_vec   (wrn_vec),
   .rdy       (rdy),
   .thr_flat  (thr_flat)
);

// File: tb/diag_monitor_regs_tb.sv
`timescale 1ns/100ps
module diag_monitor_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [2:0]  smp_sel = '0;
   logic [15:0] smp_data = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        txdis_pin = 1'b0;
   logic        los_pin = 1'b0;
   logic        tx_off;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   diag_monitor_regs u_dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_sel(smp_sel),
      .smp_data(smp_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .txdis_pin(txdis_pin),
      .los_pin(los_pin), .tx_off(tx_off)
   );

   // behavioural reference state
   logic [7:0]  m_thr [40];
   logic [15:0] m_val [5];
   logic [9:0]  m_alm, m_wrn;
   logic [4:0]  m_seen;
   logic        m_soft;

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] lim(input int q, input int k);
      return {m_thr[q*8 + k*2], m_thr[q*8 + k*2 + 1]};
   endfunction

   function automatic int as_num(input int q, input logic [15:0] w);
      if (q == 0) return int'($signed(w));
      return int'({16'd0, w});
   endfunction

   function automatic logic [7:0] m_read(input int a);
      if (a < 40) return m_thr[a];
      if (a >= 96 && a < 106) begin
         if ((a - 96) % 2 == 0) return m_val[(a-96)/2][15:8];
         return m_val[(a-96)/2][7:0];
      end
      if (a == 110) return {txdis_pin | m_soft, m_soft, 4'b0000, los_pin, ~(&m_seen)};
      if (a == 112) return m_alm[9:2];
      if (a == 113) return {m_alm[1:0], 6'd0};
      if (a == 116) return m_wrn[9:2];
      if (a == 117) return {m_wrn[1:0], 6'd0};
      return 8'h00;
   endfunction

   function automatic string tag_of(input int a);
      if (a < 40) return "R2";
      if (a >= 96 && a < 106) return "R3";
      if (a == 110) return "R7";
      if (a == 112 || a == 113) return "R5";
      if (a == 116 || a == 117) return "R6";
      return "R11";
   endfunction

   // model step and per-clock comparison
   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 40; i++) m_thr[i] = 8'h00;
         for (int i = 0; i < 5; i++) m_val[i] = 16'h0000;
         m_alm = '0; m_wrn = '0; m_seen = '0; m_soft = 1'b0;
      end else begin
         if (smp_valid && smp_sel < 3'd5) begin
            int q, v;
            q = int'(smp_sel);
            v = as_num(q, smp_data);
            m_val[q] = smp_data;
            m_seen[q] = 1'b1;
            m_alm[9-2*q] = v > as_num(q, lim(q, 0));
            m_alm[8-2*q] = v < as_num(q, lim(q, 1));
            m_wrn[9-2*q] = v > as_num(q, lim(q, 2));
            m_wrn[8-2*q] = v < as_num(q, lim(q, 3));
         end
         if (wr_en) begin
            if (wr_addr < 8'd40) m_thr[wr_addr] = wr_data;
            if (wr_addr == 8'd110) m_soft = wr_data[6];
         end
         check(tag_of(int'(rd_addr)), rd_data, m_read(int'(rd_addr)));
         check("R8", {7'd0, tx_off}, {7'd0, txdis_pin | m_soft});
      end
   end

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic smp(input int q, input logic [15:0] d);
      @(negedge clk); #1;
      smp_valid = 1'b1; smp_sel = 3'(q); smp_data = d;
      @(negedge clk); #1;
      smp_valid = 1'b0;
   endtask

   task automatic ex(input int a, input logic [7:0] e, input string tag);
      @(negedge clk); #1;
      rd_addr = 8'(a);
      #1 check(tag, rd_data, e);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      // reset state
      ex(110, 8'h01, "R9");
      ex(112, 8'h00, "R5");
      ex(3,   8'h00, "R2");
      check("R8", {7'd0, tx_off}, 8'h00);

      // temperature limits: HA 0x0050, LA 0xFF00 (-256), HW 0x0040, LW 0x0000
      wr(0, 8'h00); wr(1, 8'h50);
      wr(2, 8'hFF); wr(3, 8'h00);
      wr(4, 8'h00); wr(5, 8'h40);
      ex(2, 8'hFF, "R2");

      // R1: -512 is below both low limits when compared signed
      smp(0, 16'hFE00);
      ex(112, 8'h40, "R1");
      ex(116, 8'h40, "R1");
      ex(96, 8'hFE, "R3");

      // R4: equal to high alarm -> no alarm, above high warning -> warning
      smp(0, 16'h0050);
      ex(112, 8'h00, "R4");
      ex(116, 8'h80, "R4");

      // R10: lower the high alarm, flags stay until resampled
      wr(1, 8'h10);
      ex(112, 8'h00, "R10");
      smp(0, 16'h0050);
      ex(112, 8'h80, "R10");
      smp(0, 16'h0010);
      ex(112, 8'h00, "R10");
      ex(116, 8'h00, "R10");

      // R9 / R12: readiness after all five quantities, bad index ignored
      smp(1, 16'h0000);
      smp(2, 16'h0000);
      smp(3, 16'h0000);
      ex(110, 8'h01, "R9");
      smp(5, 16'hABCD);
      ex(110, 8'h01, "R12");
      ex(96, 8'h00, "R12");
      ex(97, 8'h10, "R12");
      smp(4, 16'h1234);
      ex(110, 8'h00, "R9");
      ex(104, 8'h12, "R3");
      ex(105, 8'h34, "R3");

      // R7 / R8: control byte
      #1 txdis_pin = 1'b1;
      ex(110, 8'h80, "R8");
      #1 txdis_pin = 1'b0;
      wr(110, 8'hFF);
      ex(110, 8'hC0, "R7");
      check("R8", {7'd0, tx_off}, 8'h01);
      wr(110, 8'h00);
      #1 los_pin = 1'b1;
      ex(110, 8'h02, "R7");
      #1 los_pin = 1'b0;

      // R11: writes to read-only and unmapped locations
      wr(112, 8'hFF);
      wr(97, 8'hAA);
      wr(60, 8'h55);
      ex(112, 8'h00, "R11");
      ex(97, 8'h10, "R11");
      ex(60, 8'h00, "R11");

      // random phase with samples clustered on the limits
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk); #1;
         smp_valid = ($urandom % 3) == 0;
         smp_sel   = 3'($urandom % 6);
         if (smp_sel < 3'd5 && ($urandom % 4) != 0)
            smp_data = lim(int'(smp_sel), int'($urandom % 4)) + 16'($urandom % 3) - 16'd1;
         else
            smp_data = 16'($urandom);
         wr_en = ($urandom % 6) == 0;
         case ($urandom % 4)
            0:       wr_addr = 8'd110;
            1:       wr_addr = 8'($urandom % 128);
            default: wr_addr = 8'($urandom % 40);
         endcase
         wr_data = 8'($urandom);
         if (($urandom % 2) == 0)
            rd_addr = 8'(112 + ($urandom % 6));
         else
            rd_addr = 8'($urandom % 128);
         if (($urandom % 50) == 0) txdis_pin = ~txdis_pin;
         if (($urandom % 50) == 0) los_pin = ~los_pin;
      end
      @(negedge clk); #1;
      smp_valid = 1'b0; wr_en = 1'b0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule